// File: doc/BRIEF.md
# Logarithmic Multi-Mode Barrel Shifter

This block shifts or rotates a data word by any amount from zero to one less than the word width in a single evaluation. It does not loop a bit per clock, and it does not use one wide multiplexer per output bit. Instead, the shift amount is split into powers of two. Each bit of the amount controls one stage, and each stage is a row of 2:1 multiplexers that either moves the word by 2^k positions or passes it through. With the default 32-bit word there are five stages, so the critical path is five multiplexer levels. The cost is 32 × 5 = 160 multiplexers, against about 1024 for a flat 32-to-1 multiplexer on every bit. For example, an amount of 13 (binary 01101) is applied as moves of 1, 0, 4 and 8 in turn.

The same stage cascade serves every mode. Right-going modes reverse the bit order of the word on the way in and again on the way out, so the stages only ever move data towards the high end. A per-mode fill rule sets what enters the vacated positions: zero, a copy of the original sign bit, or the bits that left the far end. The data width is a parameter that must be a power of two, and the amount width is derived from it. An optional output register, selected by a parameter, gives the result a clocked boundary.

Top module: `barrel_shifter`

## Requirements
- R1: Mode code 3'b000 (logical left) gives the data word shifted towards the MSB by the amount, with zeros entering at the LSB end.
- R2: Mode code 3'b001 (logical right) gives the data word shifted towards the LSB by the amount, with zeros entering at the MSB end.
- R3: Mode code 3'b010 (arithmetic right) shifts towards the LSB and fills every vacated high position with the input's MSB, so the result equals the signed right shift.
- R4: Mode code 3'b011 (rotate left) moves bits towards the MSB, and bits leaving the MSB end re-enter at the LSB end. The population count is preserved.
- R5: Mode code 3'b100 (rotate right) moves bits towards the LSB, and bits leaving the LSB end re-enter at the MSB end. The population count is preserved.
- R6: An amount of zero returns the data word unchanged in every mode.
- R7: Mode codes 3'b101, 3'b110 and 3'b111 return the data word unchanged whatever the amount.
- R8: With REG_OUT=1 the result appears on data_o after the next rising clock edge and is held until the following edge. A synchronous active-high rst clears data_o to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| data_i | input | W | Word to shift |
| amount_i | input | log2(W) | Shift or rotate distance |
| mode_i | input | 3 | Operation select, encoding as in R1 to R8 |
| data_o | output | W | Shifted or rotated word |

## Verification
Every mode code, including the three unused ones, is swept over every amount from 0 to 31 with a set of data words. Each word is chosen to expose a different kind of error:
- A single set LSB and a single set MSB show which end receives the fill.
- All-ones and all-zeros words show whether zero fill or sign fill is applied.
- Words with the MSB set and with the MSB clear tell arithmetic fill apart from logical fill.
- Irregular words such as 32'hDEADBEEF and 32'h12345678 catch a stage that moves by the wrong power of two, or that is wired to the wrong amount bit.

Separate checks confirm the one-cycle latency and the synchronous clear of the output register.

// File: rtl/bs_pkg.sv
package bs_pkg;

    typedef enum logic [2:0] {
        OP_SLL  = 3'b000,
        OP_SRL  = 3'b001,
        OP_SRA  = 3'b010,
        OP_ROL  = 3'b011,
        OP_ROR  = 3'b100
    } shift_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  active;
        logic  mirror;
        fill_e fill;
    } op_cfg_t;

    function automatic op_cfg_t decode_op(logic [2:0] code);
        op_cfg_t c;
        c.active = 1'b1;
        c.mirror = 1'b0;
        c.fill   = FILL_ZERO;
        case (code)
            OP_SLL: ;
            OP_SRL: c.mirror = 1'b1;
            OP_SRA: begin c.mirror = 1'b1; c.fill = FILL_SIGN; end
            OP_ROL: c.fill = FILL_WRAP;
            OP_ROR: begin c.mirror = 1'b1; c.fill = FILL_WRAP; end
            default: c.active = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bs_mirror.sv
module bs_mirror #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] flipped;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign flipped[i] = d[W-1-i];
    end

    assign q = en ? flipped : d;
endmodule

// File: rtl/bs_stage.sv
module bs_stage
    import bs_pkg::*;
#(
    parameter int W  = 32,
    parameter int SH = 1
) (
    input  logic         en,
    input  fill_e        fill,
    input  logic         sign,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] moved;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i >= SH) begin : g_inner
            assign moved[i] = d[i-SH];
        end else begin : g_edge
            always_comb begin
                case (fill)
                    FILL_WRAP: moved[i] = d[i-SH+W];
                    FILL_SIGN: moved[i] = sign;
                    default:   moved[i] = 1'b0;
                endcase
            end
        end
        assign q[i] = en ? moved[i] : d[i];
    end
endmodule

// File: rtl/bs_cascade.sv
module bs_cascade
    import bs_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [SW-1:0] amount,
    input  fill_e         fill,
    input  logic          sign,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);
    logic [W-1:0] lvl [0:SW];

    assign lvl[0] = d;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        bs_stage #(.W(W), .SH(1 << k)) i_stage (
            .en   (amount[k]),
            .fill (fill),
            .sign (sign),
            .d    (lvl[k]),
            .q    (lvl[k+1])
        );
    end

    assign q = lvl[SW];
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
    import bs_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int SW     = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amount_i,
    input  logic [2:0]    mode_i,
    output logic [W-1:0]  data_o
);
    initial begin
        if ((1 << SW) != W || W < 2) $error("barrel_shifter: W must be a power of two");
    end

    op_cfg_t       cfg;
    logic [SW-1:0] amt_eff;
    logic [W-1:0]  pre, post, result;

    assign cfg     = decode_op(mode_i);
    assign amt_eff = cfg.active ? amount_i : '0;

    bs_mirror #(.W(W)) i_mirror_in (
        .en (cfg.mirror),
        .d  (data_i),
        .q  (pre)
    );

    bs_cascade #(.W(W), .SW(SW)) i_cascade (
        .amount (amt_eff),
        .fill   (cfg.fill),
        .sign   (data_i[W-1]),
        .d      (pre),
        .q      (post)
    );

    bs_mirror #(.W(W)) i_mirror_out (
        .en (cfg.mirror),
        .d  (post),
        .q  (result)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) data_o <= '0;
            else     data_o <= result;
        end
    end else begin : g_comb
        logic unused_ok;
        assign unused_ok = clk ^ rst;
        assign data_o    = result;
    end
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int SW     = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  data_i,
    input logic [SW-1:0] amount_i,
    input logic [2:0]    mode_i,
    input logic [W-1:0]  data_o
);
    if (REG_OUT) begin : g_seq
        AST_SLL_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
            (mode_i == 3'b000 && amount_i != '0) |=> (data_o[0] == 1'b0)); // R1
        AST_SRL_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
            (mode_i == 3'b001 && amount_i != '0) |=> (data_o[W-1] == 1'b0)); // R2
        AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
            (mode_i == 3'b010) |=> (data_o[W-1] == $past(data_i[W-1]))); // R3
        AST_ROL_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
            (mode_i == 3'b011) |=> ($countones(data_o) == $countones($past(data_i)))); // R4
        AST_ROR_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
            (mode_i == 3'b100) |=> ($countones(data_o) == $countones($past(data_i)))); // R5
        AST_ZERO_AMOUNT_PASS: assert property (@(posedge clk) disable iff (rst)
            (amount_i == '0) |=> (data_o == $past(data_i))); // R6
        AST_UNUSED_CODE_PASS: assert property (@(posedge clk) disable iff (rst)
            (mode_i > 3'b100) |=> (data_o == $past(data_i))); // R7
        AST_RESET_CLEARS: assert property (@(posedge clk)
            rst |=> (data_o == '0)); // R8
    end else begin : g_comb
        always_comb begin
            if (mode_i > 3'b100)
                AST_UNUSED_CODE_COMB: assert (data_o == data_i); // R7
        end
    end
endmodule

bind barrel_shifter bs_checker #(.W(W), .REG_OUT(REG_OUT)) i_bs_checker (
    .clk      (clk),
    .rst      (rst),
    .data_i   (data_i),
    .amount_i (amount_i),
    .mode_i   (mode_i),
    .data_o   (data_o)
);

// File: tb/test_barrel_shifter.sv
module test_barrel_shifter;
    localparam int W  = 32;
    localparam int SW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  data_i = '0;
    logic [SW-1:0] amount_i = '0;
    logic [2:0]    mode_i = 3'b000;
    logic [W-1:0]  data_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    barrel_shifter #(.W(W), .REG_OUT(1'b1)) i_barrel_shifter (
        .clk      (clk),
        .rst      (rst),
        .data_i   (data_i),
        .amount_i (amount_i),
        .mode_i   (mode_i),
        .data_o   (data_o)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] d, int a, logic [2:0] m);
        logic [W-1:0] r;
        case (m)
            3'b000: r = d << a;
            3'b001: r = d >> a;
            3'b010: r = $unsigned($signed(d) >>> a);
            3'b011: r = (a == 0) ? d : ((d << a) | (d >> (W - a)));
            3'b100: r = (a == 0) ? d : ((d >> a) | (d << (W - a)));
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic string tag_of(int a, logic [2:0] m);
        if (m > 3'b100) return "R7";
        if (a == 0)     return "R6";
        case (m)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] d, int a, logic [2:0] m);
        @(negedge clk);
        data_i   = d;
        amount_i = a[SW-1:0];
        mode_i   = m;
        @(negedge clk);
        check(tag_of(a, m), data_o, model(d, a, m));
    endtask

    logic [W-1:0] pats [8];

    initial begin
        pats[0] = 32'h0000_0001;
        pats[1] = 32'h8000_0000;
        pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h0000_0000;
        pats[4] = 32'h7FFF_FFFF;
        pats[5] = 32'hDEAD_BEEF;
        pats[6] = 32'h1234_5678;
        pats[7] = 32'h8000_0001;

        data_i = 32'hA5A5_A5A5;
        repeat (2) @(negedge clk);
        check("R8", data_o, '0);

        @(negedge clk);
        rst = 1'b0;

        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 8; p++)
                for (int a = 0; a < W; a++)
                    apply(pats[p], a, m[2:0]);

        // R1 example: amount 13 built from stages 1, 4 and 8
        apply(32'h0000_0003, 13, 3'b000);

        // R8: output holds until the next rising edge
        @(negedge clk);
        data_i = 32'h0F0F_0000; amount_i = 4; mode_i = 3'b001;
        #1 check("R8", data_o, 32'h0000_6000);
        @(negedge clk);
        check("R8", data_o, 32'h00F0_F000);

        // R8: synchronous clear
        @(negedge clk);
        rst = 1'b1;
        #1 check("R8", data_o, 32'h00F0_F000);
        @(negedge clk);
        check("R8", data_o, '0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule